// File: doc/BRIEF.md
# Page Protection and Fault Classifier

This block sits after a page translation lookup. It decides whether a translated access may proceed, and it builds the status word that describes a refused access. Each strobed request carries the access kind (load, store or instruction fetch), the privilege state, two segment key bits and a segment no-execute bit, the two-bit protection field of the matching page entry, and a code that reports how the lookup ended.

The privilege state picks one key bit, and that key decodes the protection field into read and write rights. Execute right depends only on the segment no-execute bit. The block compares these rights with the right the access needs, and it ranks the possible faults as follows: segment no-execute on a fetch, then a missing page entry, then a rights refusal. It reports the granted rights, a fault flag, the fault class and a 32-bit status word. All results are registered and appear one cycle after the strobe.

Top module: `pfc_classifier`

## Requirements
- R1: The key is `seg_key_usr` when `user_mode` is 1 and `seg_key_sup` when `user_mode` is 0.
- R2: With key 0, protection values 0, 1 and 2 grant read and write, and value 3 grants read only.
- R3: With key 1, protection value 0 grants no read or write, values 1 and 3 grant read only, and value 2 grants read and write.
- R4: `grant_x` is 1 exactly when `seg_noexec` is 0 and a page entry was used. The decoded rights are reported only when a page entry was used, that is with lookup code 1 (hit) or with lookup code 2 on a load or store. In every other case all three grants are 0.
- R5: When a load (access code 0) lacks read right, the status word is 0x08000000. When a store (access code 1) lacks write right, it is 0x0A000000. Access code 3 behaves as a load.
- R6: A load or store with lookup code 0 (miss) or 3 (also treated as a miss) faults with status 0x40000000 for a load and 0x42000000 for a store.
- R7: A fetch (access code 2) faults with status 0x10000000 when its segment is no-execute, with 0x40000000 when no page entry exists, and with 0x08000000 when it lacks execute right.
- R8: On a fetch, `seg_noexec`=1 or lookup code 2 gives the no-execute fault whatever the lookup result and the protection field are.
- R9: `fault_instr` is 1 for a fetch and 0 for every other access code.
- R10: When `fault` is 0, `status` is 0. When `fault` is 1, `status` is nonzero.
- R11: Results appear one cycle after `in_valid` together with a one-cycle `out_valid` pulse. The results hold while no request is strobed, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| user_mode | input | 1 | 1 for user privilege, 0 for supervisor |
| seg_key_sup | input | 1 | Segment key used in supervisor state |
| seg_key_usr | input | 1 | Segment key used in user state |
| seg_noexec | input | 1 | Segment no-execute bit |
| page_pp | input | 2 | Page protection field |
| lookup_code | input | 2 | 0 miss, 1 hit, 2 segment no-execute, 3 treated as miss |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| grant_r | output | 1 | Read right granted |
| grant_w | output | 1 | Write right granted |
| grant_x | output | 1 | Execute right granted |
| fault | output | 1 | Access refused |
| fault_instr | output | 1 | Fault class: 1 instruction, 0 data |
| status | output | 32 | Fault syndrome, 0 when no fault |

## Verification
On every cycle the assertions check the following: the one-cycle latency and the output hold, the fault class, that the status is zero exactly when there is no fault, that a no-execute segment removes execute right, and that the no-execute fault wins on a fetch. Only the bench scenarios can show the two key decode tables, the selection of the key by privilege, and the exact syndrome for each access kind and lookup code. To do this the bench sweeps every combination of inputs against an independent model.

// File: rtl/pfc_pkg.sv
// pfc_pkg: shared encodings for the page protection and fault classifier.
// Assumes a 32-bit status word and a two-bit protection field.
package pfc_pkg;
    localparam int PP_W     = 2;
    localparam int STATUS_W = 32;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_HIT   = 2'd1,
        LK_SEGNX = 2'd2,
        LK_RSVD  = 2'd3
    } lk_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rights_t;

    localparam logic [STATUS_W-1:0] SYN_NONE      = '0;
    localparam logic [STATUS_W-1:0] SYN_DENY_LOAD = 32'h0800_0000;
    localparam logic [STATUS_W-1:0] SYN_DENY_STOR = 32'h0A00_0000;
    localparam logic [STATUS_W-1:0] SYN_MISS_LOAD = 32'h4000_0000;
    localparam logic [STATUS_W-1:0] SYN_MISS_STOR = 32'h4200_0000;
    localparam logic [STATUS_W-1:0] SYN_SEG_NX    = 32'h1000_0000;
endpackage

// File: rtl/pfc_rights.sv
// pfc_rights: picks the access key by privilege and decodes the page
// protection field into read/write rights; execute comes from the segment.
// Assumes inputs are stable combinational values for the current request.
module pfc_rights
    import pfc_pkg::*;
(
    input  logic            user_mode,
    input  logic            key_sup,
    input  logic            key_usr,
    input  logic            seg_noexec,
    input  logic [PP_W-1:0] pp,
    output rights_t         rights
);
    logic key;

    // Select the key bit for the current privilege level.
    always_comb key = user_mode ? key_usr : key_sup;

    // Decode the protection field through the table of the selected key.
    always_comb begin
        rights = '0;
        if (!key) begin
            rights.r = 1'b1;
            rights.w = (pp != 2'd3);
        end else begin
            rights.r = (pp != 2'd0);
            rights.w = (pp == 2'd2);
        end
        rights.x = !seg_noexec;
    end
endmodule

// File: rtl/pfc_fault.sv
// pfc_fault: ranks fault causes and encodes the status word.
// Ranking: segment no-execute on a fetch, then missing entry, then rights.
// Assumes rights come from pfc_rights for the same request.
module pfc_fault
    import pfc_pkg::*;
(
    input  acc_e                  acc,
    input  lk_e                   lookup,
    input  logic                  seg_noexec,
    input  rights_t               rights,
    output rights_t               grant,
    output logic                  fault,
    output logic                  instr,
    output logic [STATUS_W-1:0]   status
);
    logic is_fetch, is_store, entry_used, need_ok;

    // Classify the access and whether a page entry applies.
    always_comb begin
        is_fetch   = (acc == ACC_FETCH);
        is_store   = (acc == ACC_STORE);
        entry_used = (lookup == LK_HIT) || (lookup == LK_SEGNX && !is_fetch);
        if (is_fetch)      need_ok = rights.x;
        else if (is_store) need_ok = rights.w;
        else               need_ok = rights.r;
    end

    // Choose fault, syndrome and reported rights in priority order.
    always_comb begin
        instr  = is_fetch;
        fault  = 1'b0;
        status = SYN_NONE;
        grant  = entry_used ? rights : '0;
        if (is_fetch && (seg_noexec || lookup == LK_SEGNX)) begin
            fault  = 1'b1;
            status = SYN_SEG_NX;
            grant  = '0;
        end else if (!entry_used) begin
            fault  = 1'b1;
            status = is_store ? SYN_MISS_STOR : SYN_MISS_LOAD;
        end else if (!need_ok) begin
            fault  = 1'b1;
            status = is_store ? SYN_DENY_STOR : SYN_DENY_LOAD;
        end
    end
endmodule

// File: rtl/pfc_outreg.sv
// pfc_outreg: captures the classifier result on a strobe and holds it.
// Assumes synchronous active-low reset clearing every output.
module pfc_outreg
    import pfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  rights_t             d_grant,
    input  logic                d_fault,
    input  logic                d_instr,
    input  logic [STATUS_W-1:0] d_status,
    output logic                q_valid,
    output rights_t             q_grant,
    output logic                q_fault,
    output logic                q_instr,
    output logic [STATUS_W-1:0] q_status
);
    // Register results for one-cycle latency, holding between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_grant  <= '0;
            q_fault  <= 1'b0;
            q_instr  <= 1'b0;
            q_status <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q_grant  <= d_grant;
                q_fault  <= d_fault;
                q_instr  <= d_instr;
                q_status <= d_status;
            end
        end
    end
endmodule

// File: rtl/pfc_classifier.sv
// pfc_classifier: top of the page protection and fault classifier.
// Combines key/rights decode, fault ranking and the output register.
// Assumes access code 3 acts as a load and lookup code 3 as a miss.
module pfc_classifier
    import pfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          acc_kind,
    input  logic                user_mode,
    input  logic                seg_key_sup,
    input  logic                seg_key_usr,
    input  logic                seg_noexec,
    input  logic [1:0]          page_pp,
    input  logic [1:0]          lookup_code,
    output logic                out_valid,
    output logic                grant_r,
    output logic                grant_w,
    output logic                grant_x,
    output logic                fault,
    output logic                fault_instr,
    output logic [31:0]         status
);
    rights_t             dec_rights, nxt_grant, q_grant;
    logic                nxt_fault, nxt_instr;
    logic [STATUS_W-1:0] nxt_status;

    pfc_rights u_rights (
        .user_mode  (user_mode),
        .key_sup    (seg_key_sup),
        .key_usr    (seg_key_usr),
        .seg_noexec (seg_noexec),
        .pp         (page_pp),
        .rights     (dec_rights)
    );

    pfc_fault u_fault (
        .acc        (acc_e'(acc_kind)),
        .lookup     (lk_e'(lookup_code)),
        .seg_noexec (seg_noexec),
        .rights     (dec_rights),
        .grant      (nxt_grant),
        .fault      (nxt_fault),
        .instr      (nxt_instr),
        .status     (nxt_status)
    );

    pfc_outreg u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d_grant  (nxt_grant),
        .d_fault  (nxt_fault),
        .d_instr  (nxt_instr),
        .d_status (nxt_status),
        .q_valid  (out_valid),
        .q_grant  (q_grant),
        .q_fault  (fault),
        .q_instr  (fault_instr),
        .q_status (status)
    );

    // Unpack registered rights onto the ports.
    always_comb begin
        grant_r = q_grant.r;
        grant_w = q_grant.w;
        grant_x = q_grant.x;
    end

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(status) && $stable(fault) && $stable(fault_instr)));
    p_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (fault_instr == ($past(acc_kind) == 2'd2)));
    p_zero_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (fault ? (status != 32'd0) : (status == 32'd0)));
    p_nx_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_kind == 2'd2 && seg_noexec) |=> (fault && status == 32'h1000_0000));
    p_noexec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seg_noexec) |=> !grant_x);
endmodule

// File: tb/tb_pfc_classifier.sv
module tb_pfc_classifier;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] acc_kind = '0;
    logic user_mode = 1'b0, seg_key_sup = 1'b0, seg_key_usr = 1'b0, seg_noexec = 1'b0;
    logic [1:0] page_pp = '0, lookup_code = '0;
    logic out_valid, grant_r, grant_w, grant_x, fault, fault_instr;
    logic [31:0] status;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    bit have_last = 1'b0;
    logic [36:0] last_exp = '0;
    logic [36:0] exp_q[$];

    always #2.5 clk = ~clk;

    pfc_classifier dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_kind(acc_kind),
        .user_mode(user_mode), .seg_key_sup(seg_key_sup), .seg_key_usr(seg_key_usr),
        .seg_noexec(seg_noexec), .page_pp(page_pp), .lookup_code(lookup_code),
        .out_valid(out_valid), .grant_r(grant_r), .grant_w(grant_w), .grant_x(grant_x),
        .fault(fault), .fault_instr(fault_instr), .status(status)
    );

    // Expected {r,w,x,fault,instr,status} built from the requirements.
    function automatic logic [36:0] model(input logic [1:0] a, input logic um, input logic ks,
                                          input logic kp, input logic nx, input logic [1:0] pp,
                                          input logic [1:0] lk);
        logic k, r, w, x, f, used, need;
        logic [31:0] s;
        k = um ? kp : ks;                                       // R1
        if (k == 1'b0) begin r = 1'b1; w = (pp != 2'd3); end    // R2
        else begin r = (pp == 2'd1 || pp == 2'd2 || pp == 2'd3); w = (pp == 2'd2); end // R3
        x = !nx;                                                // R4
        f = 1'b0; s = 32'd0;
        if (a == 2'd2) begin
            used = (lk == 2'd1);
            if (nx || lk == 2'd2) begin f = 1'b1; s = 32'h1000_0000; used = 1'b0; end // R7 R8
            else if (!used) begin f = 1'b1; s = 32'h4000_0000; end                 // R7
            else if (!x) begin f = 1'b1; s = 32'h0800_0000; end
        end else begin
            used = (lk == 2'd1 || lk == 2'd2);
            need = (a == 2'd1) ? w : r;
            if (!used) begin f = 1'b1; s = (a == 2'd1) ? 32'h4200_0000 : 32'h4000_0000; end // R6
            else if (!need) begin f = 1'b1; s = (a == 2'd1) ? 32'h0A00_0000 : 32'h0800_0000; end // R5
        end
        if (!used) begin r = 1'b0; w = 1'b0; x = 1'b0; end
        return {r, w, x, f, (a == 2'd2), s};                   // R9 R10
    endfunction

    task automatic check(input logic [36:0] got, input logic [36:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got rwx=%b f=%b i=%b st=%h exp rwx=%b f=%b i=%b st=%h",
                     tag, got[36:34], got[33], got[32], got[31:0],
                     exp[36:34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic drive(input logic [1:0] a, input logic um, input logic ks, input logic kp,
                         input logic nx, input logic [1:0] pp, input logic [1:0] lk);
        @(negedge clk);
        in_valid = 1'b1; acc_kind = a; user_mode = um; seg_key_sup = ks;
        seg_key_usr = kp; seg_noexec = nx; page_pp = pp; lookup_code = lk;
        exp_q.push_back(model(a, um, ks, kp, nx, pp, lk));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            acc_kind = 2'd2; seg_noexec = 1'b1; lookup_code = 2'd0; // would change results if captured
        end
    endtask

    // Monitor: pop expected items as results appear; check hold otherwise.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [36:0] got;
            got = {grant_r, grant_w, grant_x, fault, fault_instr, status};
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_errors++;
                    $display("FAIL R11: got out_valid=1 exp 0 (no request pending)");
                end else begin
                    logic [36:0] e;
                    e = exp_q.pop_front();
                    check(got, e, "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 result");
                    last_exp = e; have_last = 1'b1;
                end
            end else if (have_last) begin
                check(got, last_exp, "R11 hold");
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({grant_r, grant_w, grant_x, fault, fault_instr, status, out_valid}, 38'd0 >> 1,
              "R11 reset");
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R11 reset: got out_valid=%b exp 0", out_valid);
        end
        rst_n = 1'b1;
        // Directed corners first.
        drive(2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1); // R1 user key1 pp0 load denied
        drive(2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 2'd1); // R1 sup key0 pp3 store denied
        drive(2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1); // R8 nx fetch with hit
        idle(3);                                           // R11 hold
        drive(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0); // R6 store miss
        drive(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2); // R5 rsvd acc as load, key1 pp0
        idle(2);
        // Exhaustive sweep.
        for (int a = 0; a < 4; a++)
            for (int u = 0; u < 2; u++)
                for (int ks = 0; ks < 2; ks++)
                    for (int kp = 0; kp < 2; kp++)
                        for (int nx = 0; nx < 2; nx++)
                            for (int pp = 0; pp < 4; pp++)
                                for (int lk = 0; lk < 4; lk++) begin
                                    drive(2'(a), 1'(u), 1'(ks), 1'(kp), 1'(nx), 2'(pp), 2'(lk));
                                    if (((a + pp + lk) % 7) == 0) idle(1);
                                end
        idle(4);
        if (exp_q.size() != 0) begin
            n_checks++; n_errors++;
            $display("FAIL R11: got %0d results missing exp 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL R11 watchdog: got hang exp completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule